// File: doc/BRIEF.md
# CAN Message Buffer Acceptance Filter

This block decides which message buffer takes an incoming CAN frame. A receiver front end hands it the frame's identifier as a parallel word with a strobe, together with a flag for the extended format and a flag for a remote request. Each buffer slot holds a stored identifier, a format bit, a direction bit (receive or transmit), a valid bit and one of four matching modes. The modes are exact compare, accept any identifier, and compare through one of two shared partial masks. One clock after the strobe, the block reports whether any slot matched and which one won. When several slots match, the lowest-numbered slot wins.

A remote frame can only match a transmit slot. When it does, the block pulses an automatic-reply output and raises that slot's transmit request. Software can also raise transmit requests. A request stays set until the transmitter reports success for that slot, so a failed attempt is retried without any further action. The block also names the lowest-numbered pending slot, which is the next one to send.

Top module: `can_msgbuf_filter`

## Requirements
- R1: After reset, `hit`, `auto_tx`, `tx_any` and every bit of `tx_pend` are 0, and every slot is invalid, so no frame is accepted until a slot is written.
- R2: `hit` is high for exactly the one cycle after a cycle with `rx_valid` high and a matching slot. In that cycle, `hit_idx` holds the winner. Without `rx_valid`, `hit` stays low.
- R3: The slot's format bit must equal `rx_ext`. A standard frame (`rx_ext`=0) compares only bits [10:0] of the identifier, and bits [28:11] of `rx_id` have no effect. An extended frame compares bits [28:0].
- R4: `cfg_mode` encodings are 00 exact (all compared bits equal), 01 any identifier, 10 through shared mask A and 11 through shared mask B. A mask bit of 1 requires that bit to be equal, and a mask bit of 0 ignores it.
- R5: When several slots match, `hit_idx` is the lowest matching index.
- R6: A slot whose valid bit is 0 never matches. When no slot matches, `hit` and `auto_tx` stay low.
- R7: A receive slot (`cfg_dir`=0) matches only data frames (`rx_rtr`=0). A transmit slot (`cfg_dir`=1) matches only remote frames (`rx_rtr`=1).
- R8: When a remote frame matches, `auto_tx` is high in the same cycle as `hit`, and `tx_pend[hit_idx]` is already set in that cycle.
- R9: `tx_set` sets `tx_pend[tx_set_idx]` at the next edge. The bit stays set until `tx_ok` arrives with the same index. A `tx_ok` for another index has no effect on it. If a set and a clear hit the same slot in the same cycle, the set wins.
- R10: `tx_any` is the OR of `tx_pend`, and `tx_next_idx` is the lowest index with its pending bit set.
- R11: A write to a slot or to a mask takes effect for frames presented from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write one slot's configuration |
| cfg_idx | input | IDX_W | Slot being written |
| cfg_valid | input | 1 | Slot valid bit |
| cfg_ext | input | 1 | Slot format: 1 extended, 0 standard |
| cfg_dir | input | 1 | Slot direction: 1 transmit, 0 receive |
| cfg_mode | input | 2 | Matching mode (see R4) |
| cfg_id | input | 29 | Stored identifier |
| mask_we | input | 1 | Write a shared mask |
| mask_sel | input | 1 | 0 selects mask A, 1 selects mask B |
| mask_val | input | 29 | Mask value |
| rx_valid | input | 1 | Identifier strobe |
| rx_id | input | 29 | Received identifier |
| rx_ext | input | 1 | Received frame is extended |
| rx_rtr | input | 1 | Received frame is a remote request |
| hit | output | 1 | A slot accepted the frame |
| hit_idx | output | IDX_W | Winning slot |
| auto_tx | output | 1 | Automatic reply to a remote frame |
| tx_set | input | 1 | Software transmit request |
| tx_set_idx | input | IDX_W | Slot requested |
| tx_ok | input | 1 | Transmission succeeded |
| tx_ok_idx | input | IDX_W | Slot that succeeded |
| tx_pend | output | NUM_BUF | Pending transmit requests |
| tx_any | output | 1 | Some request is pending |
| tx_next_idx | output | IDX_W | Lowest pending slot |

## Verification
The bench builds the block with `NUM_BUF`=4, so every slot's mode, format and direction can be set by hand. In that setting, all 2048 standard identifiers are swept for both data and remote frames, with junk placed in the ignored upper bits. Overlapping mask and exact slots bring the priority rule into every sweep. A long pseudo-random pass over extended identifiers, with forced mask hits, exercises the full 29-bit compare. Directed sequences cover invalid slots, the direction rule, and the set, clear, collision and retry behaviour of the transmit requests.

// File: rtl/accf_pkg.sv
// Shared types of the acceptance filter.
// Assumes identifiers are carried right-aligned in a 29-bit word.
package accf_pkg;
    localparam int ID_W  = 29;
    localparam int STD_W = 11;

    typedef enum logic [1:0] {
        AM_EXACT  = 2'b00,
        AM_ANY    = 2'b01,
        AM_MASK_A = 2'b10,
        AM_MASK_B = 2'b11
    } acc_mode_e;

    typedef struct packed {
        logic            valid;
        logic            ext;
        logic            dir;
        acc_mode_e       mode;
        logic [ID_W-1:0] id;
    } slot_cfg_t;
endpackage

// File: rtl/accf_slot_regs.sv
// Slot configuration store and the two shared masks.
// Assumes at most one slot write and one mask write per cycle; writes beyond NUM_BUF are dropped.
module accf_slot_regs
    import accf_pkg::*;
#(
    parameter int NUM_BUF = 16,
    localparam int IDX_W = $clog2(NUM_BUF)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [IDX_W-1:0]            cfg_idx,
    input  slot_cfg_t                   cfg_new,
    input  logic                        mask_we,
    input  logic                        mask_sel,
    input  logic [ID_W-1:0]             mask_val,
    output slot_cfg_t [NUM_BUF-1:0]     slots,
    output logic [ID_W-1:0]             mask_a,
    output logic [ID_W-1:0]             mask_b
);
    // Slot registers: cleared (invalid) on reset, one written per cycle (R1, R11).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BUF; i++) slots[i] <= '0;
        end else if (cfg_we && (int'(cfg_idx) < NUM_BUF)) begin
            slots[cfg_idx] <= cfg_new;
        end
    end

    // Shared partial masks: zero (ignore all) after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_a <= '0;
            mask_b <= '0;
        end else if (mask_we) begin
            if (mask_sel) mask_b <= mask_val;
            else          mask_a <= mask_val;
        end
    end
endmodule

// File: rtl/accf_match.sv
// Per-slot identifier compare, purely combinational.
// Assumes a standard identifier sits in bits [10:0]; higher bits are then don't-care.
module accf_match
    import accf_pkg::*;
#(
    parameter int NUM_BUF = 16
) (
    input  slot_cfg_t [NUM_BUF-1:0] slots,
    input  logic [ID_W-1:0]         mask_a,
    input  logic [ID_W-1:0]         mask_b,
    input  logic [ID_W-1:0]         rx_id,
    input  logic                    rx_ext,
    input  logic                    rx_rtr,
    output logic [NUM_BUF-1:0]      match_vec
);
    localparam logic [ID_W-1:0] STD_SPAN = ID_W'((1 << STD_W) - 1);

    logic [ID_W-1:0] span;
    assign span = rx_ext ? '1 : STD_SPAN;   // R3: bits compared for this format

    for (genvar b = 0; b < NUM_BUF; b++) begin : g_slot
        logic [ID_W-1:0] care;
        logic [ID_W-1:0] diff;

        // Pick the compare mask for this slot's mode (R4).
        always_comb begin
            case (slots[b].mode)
                AM_EXACT:  care = '1;
                AM_ANY:    care = '0;
                AM_MASK_A: care = mask_a;
                default:   care = mask_b;
            endcase
        end

        assign diff = (rx_id ^ slots[b].id) & care & span;
        // R6 valid, R3 format, R7 direction, R4 identifier
        assign match_vec[b] = slots[b].valid && (slots[b].ext == rx_ext)
                           && (slots[b].dir == rx_rtr) && (diff == '0);
    end
endmodule

// File: rtl/accf_prio_enc.sv
// Lowest-index-first priority encoder.
// Assumes N >= 2.
module accf_prio_enc #(
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit is written last (R5, R10).
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/accf_txreq.sv
// Transmit request bits: set by software or by an automatic reply, cleared only on success.
// Assumes set and clear arrive as per-slot vectors; a set beats a simultaneous clear.
module accf_txreq #(
    parameter int NUM_BUF = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BUF-1:0] set_vec,
    input  logic [NUM_BUF-1:0] clr_vec,
    output logic [NUM_BUF-1:0] pend
);
    // Request register update (R9).
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_vec) | set_vec;
    end

    for (genvar i = 0; i < NUM_BUF; i++) begin : g_chk
        // R9: a request survives every cycle without a success for its slot
        p_hold_until_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(pend[i]) && !$past(clr_vec[i])) |-> pend[i]);
        // R9: a success with no new request drops the bit
        p_ok_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(clr_vec[i]) && !$past(set_vec[i])) |-> !pend[i]);
    end
endmodule

// File: rtl/can_msgbuf_filter.sv
// Acceptance filter for a bank of CAN message buffers.
// Registers the winning slot one clock after the identifier strobe and raises automatic
// reply requests for remote frames. Assumes rx_id is stable while rx_valid is high.
module can_msgbuf_filter
    import accf_pkg::*;
#(
    parameter int NUM_BUF = 16,
    localparam int IDX_W = $clog2(NUM_BUF)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic               cfg_valid,
    input  logic               cfg_ext,
    input  logic               cfg_dir,
    input  logic [1:0]         cfg_mode,
    input  logic [28:0]        cfg_id,
    input  logic               mask_we,
    input  logic               mask_sel,
    input  logic [28:0]        mask_val,
    input  logic               rx_valid,
    input  logic [28:0]        rx_id,
    input  logic               rx_ext,
    input  logic               rx_rtr,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx,
    output logic               auto_tx,
    input  logic               tx_set,
    input  logic [IDX_W-1:0]   tx_set_idx,
    input  logic               tx_ok,
    input  logic [IDX_W-1:0]   tx_ok_idx,
    output logic [NUM_BUF-1:0] tx_pend,
    output logic               tx_any,
    output logic [IDX_W-1:0]   tx_next_idx
);
    localparam logic [NUM_BUF-1:0] NB_ONE = NUM_BUF'(1);

    slot_cfg_t [NUM_BUF-1:0] slots;
    slot_cfg_t               cfg_new;
    logic [ID_W-1:0]         mask_a, mask_b;
    logic [NUM_BUF-1:0]      match_vec;
    logic                    win_any;
    logic [IDX_W-1:0]        win_idx;
    logic [NUM_BUF-1:0]      set_vec, clr_vec;
    logic                    take;

    assign cfg_new = '{valid: cfg_valid, ext: cfg_ext, dir: cfg_dir,
                       mode: acc_mode_e'(cfg_mode), id: cfg_id};

    accf_slot_regs #(.NUM_BUF(NUM_BUF)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_new(cfg_new),
        .mask_we(mask_we), .mask_sel(mask_sel), .mask_val(mask_val),
        .slots(slots), .mask_a(mask_a), .mask_b(mask_b)
    );

    accf_match #(.NUM_BUF(NUM_BUF)) u_match (
        .slots(slots), .mask_a(mask_a), .mask_b(mask_b),
        .rx_id(rx_id), .rx_ext(rx_ext), .rx_rtr(rx_rtr), .match_vec(match_vec)
    );

    accf_prio_enc #(.N(NUM_BUF)) u_rx_pick (
        .req(match_vec), .any(win_any), .idx(win_idx)
    );

    assign take = rx_valid && win_any;

    // Result registers: one-cycle hit and reply pulses, index held between frames (R2, R8).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit     <= 1'b0;
            auto_tx <= 1'b0;
            hit_idx <= '0;
        end else begin
            hit     <= take;
            auto_tx <= take && rx_rtr;
            if (take) hit_idx <= win_idx;
        end
    end

    // Request vectors: software set, automatic reply set, success clear (R8, R9).
    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        if (tx_set)          set_vec = set_vec | (NB_ONE << tx_set_idx);
        if (take && rx_rtr)  set_vec = set_vec | (NB_ONE << win_idx);
        if (tx_ok)           clr_vec = NB_ONE << tx_ok_idx;
    end

    accf_txreq #(.NUM_BUF(NUM_BUF)) u_txreq (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .pend(tx_pend)
    );

    accf_prio_enc #(.N(NUM_BUF)) u_tx_pick (
        .req(tx_pend), .any(tx_any), .idx(tx_next_idx)
    );

    // R2: a hit only follows a strobe
    p_hit_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(rx_valid));
    // R2: an accepted strobe yields a hit naming the encoder's winner
    p_hit_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (hit && hit_idx == $past(win_idx)));
    // R5: no lower-numbered slot also matched
    p_lowest_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ((match_vec & ((NB_ONE << win_idx) - NB_ONE)) == '0));
    // R6: the winner is a valid slot
    p_winner_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> slots[win_idx].valid);
    // R7: the winner's direction agrees with the frame type
    p_dir_rule_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (slots[win_idx].dir == rx_rtr));
    // R8: an automatic reply coincides with a hit whose request is already pending
    p_reply_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        auto_tx |-> (hit && tx_pend[hit_idx]));
    // R10: the next slot to send is pending whenever anything is
    p_next_is_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_any |-> tx_pend[tx_next_idx]);
endmodule

// File: tb/can_msgbuf_filter_test.sv
module can_msgbuf_filter_test;
    localparam int NB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 0, cfg_valid = 0, cfg_ext = 0, cfg_dir = 0;
    logic [1:0] cfg_idx = 0, cfg_mode = 0;
    logic [28:0] cfg_id = 0, mask_val = 0, rx_id = 0;
    logic mask_we = 0, mask_sel = 0, rx_valid = 0, rx_ext = 0, rx_rtr = 0;
    logic hit, auto_tx, tx_any;
    logic [1:0] hit_idx, tx_next_idx;
    logic tx_set = 0, tx_ok = 0;
    logic [1:0] tx_set_idx = 0, tx_ok_idx = 0;
    logic [NB-1:0] tx_pend;

    int n_chk = 0, n_fail = 0, cyc = 0;

    // bench-side view of the configuration
    logic        m_valid [NB];
    logic        m_ext   [NB];
    logic        m_dir   [NB];
    logic [1:0]  m_mode  [NB];
    logic [28:0] m_id    [NB];
    logic [28:0] m_ma = 0, m_mb = 0;
    logic [NB-1:0] m_pend = 0;

    always #4 clk = ~clk;   // 125 MHz

    can_msgbuf_filter #(.NUM_BUF(NB)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
        .cfg_ext(cfg_ext), .cfg_dir(cfg_dir), .cfg_mode(cfg_mode), .cfg_id(cfg_id),
        .mask_we(mask_we), .mask_sel(mask_sel), .mask_val(mask_val),
        .rx_valid(rx_valid), .rx_id(rx_id), .rx_ext(rx_ext), .rx_rtr(rx_rtr),
        .hit(hit), .hit_idx(hit_idx), .auto_tx(auto_tx),
        .tx_set(tx_set), .tx_set_idx(tx_set_idx), .tx_ok(tx_ok), .tx_ok_idx(tx_ok_idx),
        .tx_pend(tx_pend), .tx_any(tx_any), .tx_next_idx(tx_next_idx)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected winner from the requirement rules: {hit, idx}
    function automatic logic [2:0] model(logic [28:0] id, logic ext, logic rtr);
        for (int i = 0; i < NB; i++) begin
            logic [28:0] care, span;
            span = ext ? 29'h1FFF_FFFF : 29'h7FF;
            case (m_mode[i])
                2'b00:   care = '1;
                2'b01:   care = '0;
                2'b10:   care = m_ma;
                default: care = m_mb;
            endcase
            if (m_valid[i] && m_ext[i] == ext && m_dir[i] == rtr && ((id ^ m_id[i]) & care & span) == 0)
                return {1'b1, 2'(i)};
        end
        return 3'b000;
    endfunction

    task automatic cfg_write(int idx, logic v, logic e, logic d, logic [1:0] md, logic [28:0] id);
        cfg_we = 1; cfg_idx = 2'(idx); cfg_valid = v; cfg_ext = e; cfg_dir = d; cfg_mode = md; cfg_id = id;
        @(negedge clk); cfg_we = 0;
        m_valid[idx] = v; m_ext[idx] = e; m_dir[idx] = d; m_mode[idx] = md; m_id[idx] = id;
    endtask

    task automatic mask_write(logic sel, logic [28:0] v);
        mask_we = 1; mask_sel = sel; mask_val = v;
        @(negedge clk); mask_we = 0;
        if (sel) m_mb = v; else m_ma = v;
    endtask

    task automatic send(logic [28:0] id, logic ext, logic rtr, string tag);
        logic [2:0] e;
        e = model(id, ext, rtr);
        rx_id = id; rx_ext = ext; rx_rtr = rtr; rx_valid = 1;
        @(negedge clk); rx_valid = 0;
        if (e[2] && rtr) m_pend[e[1:0]] = 1'b1;
        chk({tag, " hit"}, 32'(hit), 32'(e[2]));
        if (e[2]) chk({tag, " hit_idx"}, 32'(hit_idx), 32'(e[1:0]));
        chk({tag, " auto_tx"}, 32'(auto_tx), 32'(e[2] & rtr));
    endtask

    function automatic logic [2:0] lowest_pend();
        for (int i = 0; i < NB; i++) if (m_pend[i]) return {1'b1, 2'(i)};
        return 3'b000;
    endfunction

    task automatic chk_pend(string tag);
        logic [2:0] lp;
        lp = lowest_pend();
        chk({tag, " tx_pend"}, 32'(tx_pend), 32'(m_pend));
        chk("R10 tx_any", 32'(tx_any), 32'(lp[2]));
        if (lp[2]) chk("R10 tx_next_idx", 32'(tx_next_idx), 32'(lp[1:0]));
    endtask

    task automatic tx_op(logic s, int si, logic o, int oi);
        tx_set = s; tx_set_idx = 2'(si); tx_ok = o; tx_ok_idx = 2'(oi);
        @(negedge clk); tx_set = 0; tx_ok = 0;
        if (o) m_pend[oi] = 1'b0;
        if (s) m_pend[si] = 1'b1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 120000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<120000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NB; i++) begin
            m_valid[i] = 0; m_ext[i] = 0; m_dir[i] = 0; m_mode[i] = 0; m_id[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state, nothing accepted with all slots invalid
        chk("R1 hit", 32'(hit), 0);
        chk("R1 auto_tx", 32'(auto_tx), 0);
        chk_pend("R1");
        send(29'h000, 0, 0, "R1");
        send(29'h1FFF_FFFF, 1, 1, "R1");

        // R2/R3/R4/R5/R7/R8: sweep every standard identifier, both frame types, junk in upper bits
        mask_write(0, 29'h700);
        mask_write(1, 29'h00F);
        cfg_write(0, 1, 0, 0, 2'b10, 29'h123);
        cfg_write(1, 1, 0, 1, 2'b00, 29'h456);
        cfg_write(2, 1, 0, 0, 2'b11, 29'h005);
        cfg_write(3, 1, 0, 1, 2'b01, 29'h000);
        for (int k = 0; k < 2048; k++) begin
            logic [28:0] junk;
            junk = 29'(k * 29'h1F3B1) << 11;
            send(junk | 29'(k), 0, 1'(k & 1), "R3 R4 R5 std sweep");
        end
        chk_pend("R8");
        for (int k = 0; k < 2048; k++) begin
            send(29'(k), 0, 0, "R4 R5 std data");
        end
        chk("R2 hit idle", 32'(hit), 0);

        // R3/R4: extended identifiers through mask A, exact and any
        mask_write(0, 29'h1FFF_0000);
        cfg_write(0, 1, 1, 0, 2'b10, 29'h1234_0000);
        cfg_write(1, 1, 0, 0, 2'b00, 29'h456);
        cfg_write(2, 1, 1, 0, 2'b00, 29'h0ABC_DEF1);
        cfg_write(3, 1, 1, 1, 2'b01, 29'h0);
        send(29'h1234_5678, 1, 0, "R3 ext maskA");
        send(29'h0ABC_DEF1, 1, 0, "R4 ext exact");
        send(29'h0ABC_DEF0, 1, 0, "R4 ext exact miss");
        send(29'h0000_0456, 1, 0, "R3 format mismatch");
        send(29'h0000_0456, 0, 0, "R3 std exact");
        begin
            logic [31:0] x;
            x = 32'h1234_5678;
            for (int k = 0; k < 3000; k++) begin
                logic [28:0] id;
                x = x * 32'd1103515245 + 32'd12345;
                id = x[28:0];
                if (k % 4 == 0) id[28:16] = 13'h1234;
                send(id, 1'(k % 3 != 0), 1'(k % 5 == 0), "R3 R4 ext sweep");
            end
        end

        // R7: same identifier in a transmit and a receive slot
        cfg_write(0, 1, 0, 1, 2'b00, 29'h321);
        cfg_write(1, 1, 0, 0, 2'b00, 29'h321);
        cfg_write(2, 0, 0, 0, 2'b00, 29'h0);
        cfg_write(3, 0, 0, 0, 2'b00, 29'h0);
        send(29'h321, 0, 0, "R7 data to rx slot");
        chk("R7 idx", 32'(hit_idx), 1);
        send(29'h321, 0, 1, "R8 remote to tx slot");
        chk("R8 idx", 32'(hit_idx), 0);
        chk_pend("R8");

        // R6: invalid slots never match
        cfg_write(1, 0, 0, 0, 2'b00, 29'h321);
        send(29'h321, 0, 0, "R6 invalid slot");
        cfg_write(0, 0, 0, 1, 2'b00, 29'h321);
        send(29'h321, 0, 1, "R6 invalid slot");

        // R11: a mask write affects the very next frame
        cfg_write(2, 1, 0, 0, 2'b10, 29'h7F0);
        mask_write(0, 29'h7F0);
        send(29'h7F3, 0, 0, "R11 mask now compares");
        mask_write(0, 29'h000);
        send(29'h003, 0, 0, "R11 mask now open");

        // R9/R10: transmit request bookkeeping
        for (int i = 0; i < NB; i++) tx_op(0, 0, 1, i);
        chk_pend("R9 cleared");
        tx_op(1, 2, 0, 0);
        chk_pend("R9 set");
        tx_op(0, 0, 1, 3);
        chk_pend("R9 other ok");
        repeat (5) @(negedge clk);
        chk_pend("R9 retry holds");
        tx_op(1, 3, 0, 0);
        tx_op(1, 1, 0, 0);
        chk_pend("R10 lowest");
        tx_op(1, 1, 1, 1);
        chk_pend("R9 set beats clear");
        tx_op(0, 0, 1, 1);
        chk_pend("R10 next after ok");
        tx_op(0, 0, 1, 2);
        tx_op(0, 0, 1, 3);
        chk_pend("R9 all done");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule